// File: doc/BRIEF.md
# Parallel Port Floppy Pin Sharing Multiplexer

This block lets one set of parallel-port connector pins serve either a standard parallel port or a floppy-drive interface. Three configuration bits select the owner: a parallel-port power bit and a two-bit floppy mode field. The block registers the selection once per clock. From that registered owner it drives the pad output values and output enables, and it routes synchronized pad inputs to whichever function is active. The function that is not active sees its inputs held at their idle levels.

When the floppy function owns the pins, it works whatever the power bit says. The parallel port's control register then reads back a fixed "no cable" pattern instead of its real contents. There are five shared pads. Pads 0 to 3 are connector pins 14 to 17. Pad 4 is an auxiliary pin whose direction in floppy use depends on the floppy mode.

Top module: `ppfd_pin_mux`

## Requirements
- R1: While rst_n is low, every pad output enable and every pad output value is 0, the registered owner is "off", and the synchronizer holds all ones. The parallel-port pin inputs therefore read 1, pp_busy_i reads 0 and fd_aux_n_i reads 1.
- R2: With cfg_fdd_mode at 00, or at the reserved code 11, and cfg_pp_power at 1, the parallel port owns the pins. Pad 0 carries the auto-feed line, pad 2 the init line and pad 3 the select-in line. Each of these takes its value and enable from the parallel-port side. Pad 1 (error) and pad 4 (busy) are never driven.
- R3: With cfg_fdd_mode at 00 or 11 and cfg_pp_power at 0, all pads are tri-stated (enable 0) and every pad output value is 0.
- R4: With cfg_fdd_mode at 01 or 10, the floppy side owns pads 0 to 3 whatever cfg_pp_power is. Those pads are driven with density select, head select, direction and step, in that pad order.
- R5: Pad 4 is driven from fd_aux_n_o in floppy mode 10. In floppy mode 01 it is an input delivered on fd_aux_n_i.
- R6: In floppy modes 01 and 10, pp_ctrl_rd reads 4'b0100: bit 0 strobe = 0, bit 1 auto-feed = 0, bit 2 init = 1, bit 3 select = 0. In all other modes it equals pp_ctrl_raw.
- R7: A change on pad_i reaches the active function's input after exactly two rising clock edges.
- R8: Inputs of an inactive function sit at their idle level. The active-low parallel inputs and fd_aux_n_i read 1, and pp_busy_i reads 0.
- R9: A configuration change takes effect on the pads at the first rising edge after it. A pad that is an input in the new mode never has its enable asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pp_power | input | 1 | Parallel-port power enable |
| cfg_fdd_mode | input | 2 | Floppy-on-port mode: 00 off, 01 mode 1, 10 mode 2, 11 reserved |
| pp_afd_o | input | 1 | Parallel auto-feed output value |
| pp_afd_oe | input | 1 | Parallel auto-feed output enable |
| pp_init_o | input | 1 | Parallel init output value |
| pp_init_oe | input | 1 | Parallel init output enable |
| pp_slin_o | input | 1 | Parallel select-in output value |
| pp_slin_oe | input | 1 | Parallel select-in output enable |
| pp_ctrl_raw | input | 4 | Parallel control register contents |
| fd_densel_n_o | input | 1 | Floppy density select |
| fd_hdsel_n_o | input | 1 | Floppy head select |
| fd_dir_n_o | input | 1 | Floppy step direction |
| fd_step_n_o | input | 1 | Floppy step pulse |
| fd_aux_n_o | input | 1 | Floppy auxiliary output, used in mode 10 |
| pad_i | input | 5 | Pad input levels |
| pad_o | output | 5 | Pad output values |
| pad_oe | output | 5 | Pad output enables |
| pp_afd_i | output | 1 | Synchronized auto-feed input to parallel port |
| pp_err_i | output | 1 | Synchronized error input to parallel port |
| pp_init_i | output | 1 | Synchronized init input to parallel port |
| pp_slin_i | output | 1 | Synchronized select-in input to parallel port |
| pp_busy_i | output | 1 | Synchronized busy input to parallel port |
| fd_aux_n_i | output | 1 | Synchronized auxiliary input to floppy side, used in mode 01 |
| pp_ctrl_rd | output | 4 | Control register readback value |

## Verification
Configuration results on the pads, the readback and the idle-level inputs are due one rising edge after the configuration inputs change. Pad input changes are due two rising edges later. Changes on the functions' own output values show up combinationally. The driver changes inputs on a falling edge and records each expected item with the cycle number in which it falls due. For pad input changes, it records one item for the first edge, still expecting the old level, and one for the second edge, expecting the new level. The monitor compares on the falling edge of exactly that cycle, so a result that is one edge early or late is reported.

// File: rtl/ppfd_pin_mux.sv
module ppfd_pin_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_pp_power,
  input  logic [1:0] cfg_fdd_mode,
  input  logic       pp_afd_o,
  input  logic       pp_afd_oe,
  input  logic       pp_init_o,
  input  logic       pp_init_oe,
  input  logic       pp_slin_o,
  input  logic       pp_slin_oe,
  input  logic [3:0] pp_ctrl_raw,
  input  logic       fd_densel_n_o,
  input  logic       fd_hdsel_n_o,
  input  logic       fd_dir_n_o,
  input  logic       fd_step_n_o,
  input  logic       fd_aux_n_o,
  input  logic [4:0] pad_i,
  output logic [4:0] pad_o,
  output logic [4:0] pad_oe,
  output logic       pp_afd_i,
  output logic       pp_err_i,
  output logic       pp_init_i,
  output logic       pp_slin_i,
  output logic       pp_busy_i,
  output logic       fd_aux_n_i,
  output logic [3:0] pp_ctrl_rd
);
  localparam int NPADS = 5;
  localparam logic [3:0] NO_CABLE = 4'b0100;

  typedef enum logic [1:0] {OWN_OFF, OWN_PP, OWN_FD1, OWN_FD2} owner_e;

  owner_e own_d, own_q;
  logic [NPADS-1:0] sync_q [SYNC_STAGES];
  logic [NPADS-1:0] pins_s, pp_oe, pp_val, fd_oe, fd_val;
  logic pp_on, fd_on;

  always_comb begin
    case (cfg_fdd_mode)
      2'b01:   own_d = OWN_FD1;
      2'b10:   own_d = OWN_FD2;
      default: own_d = cfg_pp_power ? OWN_PP : OWN_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_OFF;
    else        own_q <= own_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= pad_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pins_s = sync_q[SYNC_STAGES-1];
  assign pp_on  = (own_q == OWN_PP);
  assign fd_on  = (own_q == OWN_FD1) || (own_q == OWN_FD2);

  assign pp_oe  = {1'b0, pp_slin_oe, pp_init_oe, 1'b0, pp_afd_oe};
  assign pp_val = {1'b0, pp_slin_o,  pp_init_o,  1'b0, pp_afd_o};
  assign fd_oe  = {own_q == OWN_FD2, 4'hf};
  assign fd_val = {fd_aux_n_o, fd_step_n_o, fd_dir_n_o, fd_hdsel_n_o, fd_densel_n_o};

  assign pad_oe = fd_on ? fd_oe : (pp_on ? pp_oe : '0);
  assign pad_o  = pad_oe & (fd_on ? fd_val : pp_val);

  assign pp_afd_i   = pp_on ? pins_s[0] : 1'b1;
  assign pp_err_i   = pp_on ? pins_s[1] : 1'b1;
  assign pp_init_i  = pp_on ? pins_s[2] : 1'b1;
  assign pp_slin_i  = pp_on ? pins_s[3] : 1'b1;
  assign pp_busy_i  = pp_on ? pins_s[4] : 1'b0;
  assign fd_aux_n_i = (own_q == OWN_FD1) ? pins_s[4] : 1'b1;

  assign pp_ctrl_rd = fd_on ? NO_CABLE : pp_ctrl_raw;

  a_r3_off_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg_fdd_mode == 2'b01 || cfg_fdd_mode == 2'b10) && !cfg_pp_power)
      |=> (pad_oe == 5'b0 && pad_o == 5'b0));

  a_r4_fd_drives_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fdd_mode == 2'b01 || cfg_fdd_mode == 2'b10)
      |=> (pad_oe[3:0] == 4'hf &&
           pad_o[3:0] == {fd_step_n_o, fd_dir_n_o, fd_hdsel_n_o, fd_densel_n_o}));

  a_r5_aux_input: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fdd_mode == 2'b01) |=> !pad_oe[4]);

  a_r5_aux_output: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fdd_mode == 2'b10) |=> (pad_oe[4] && pad_o[4] == fd_aux_n_o));

  a_r6_no_cable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fdd_mode == 2'b01 || cfg_fdd_mode == 2'b10) |=> (pp_ctrl_rd == NO_CABLE));

  a_r2_inputs_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_fdd_mode == 2'b01 || cfg_fdd_mode == 2'b10) |=> (!pad_oe[1] && !pad_oe[4]));

  a_r8_aux_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fdd_mode != 2'b01) |=> fd_aux_n_i);

  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (pad_oe == 5'b0);
  end
endmodule

// File: tb/ppfd_pin_mux_tb_top.sv
module ppfd_pin_mux_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pp_power = 1'b0;
  logic [1:0] cfg_fdd_mode = 2'b00;
  logic pp_afd_o = 0, pp_afd_oe = 0, pp_init_o = 0, pp_init_oe = 0, pp_slin_o = 0, pp_slin_oe = 0;
  logic [3:0] pp_ctrl_raw = 4'b0000;
  logic fd_densel_n_o = 1, fd_hdsel_n_o = 1, fd_dir_n_o = 1, fd_step_n_o = 1, fd_aux_n_o = 1;
  logic [4:0] pad_i = 5'b11111;
  logic [4:0] pad_o, pad_oe;
  logic pp_afd_i, pp_err_i, pp_init_i, pp_slin_i, pp_busy_i, fd_aux_n_i;
  logic [3:0] pp_ctrl_rd;

  ppfd_pin_mux dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pp_power(cfg_pp_power), .cfg_fdd_mode(cfg_fdd_mode),
    .pp_afd_o(pp_afd_o), .pp_afd_oe(pp_afd_oe), .pp_init_o(pp_init_o), .pp_init_oe(pp_init_oe),
    .pp_slin_o(pp_slin_o), .pp_slin_oe(pp_slin_oe), .pp_ctrl_raw(pp_ctrl_raw),
    .fd_densel_n_o(fd_densel_n_o), .fd_hdsel_n_o(fd_hdsel_n_o), .fd_dir_n_o(fd_dir_n_o),
    .fd_step_n_o(fd_step_n_o), .fd_aux_n_o(fd_aux_n_o), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe(pad_oe), .pp_afd_i(pp_afd_i), .pp_err_i(pp_err_i), .pp_init_i(pp_init_i),
    .pp_slin_i(pp_slin_i), .pp_busy_i(pp_busy_i), .fd_aux_n_i(fd_aux_n_i), .pp_ctrl_rd(pp_ctrl_rd)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    string       req;
    logic [19:0] v;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  int own_m = 0;
  logic [4:0] syn = 5'b11111;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [19:0] observed();
    return {pad_oe, pad_o, pp_ctrl_rd, pp_afd_i, pp_err_i, pp_init_i, pp_slin_i, pp_busy_i, fd_aux_n_i};
  endfunction

  function automatic int owner_of(logic [1:0] m, logic p);
    if (m == 2'b01) return 2;
    if (m == 2'b10) return 3;
    return p ? 1 : 0;
  endfunction

  function automatic logic [19:0] expected();
    logic [4:0] oe, o;
    logic [3:0] rd;
    logic [5:0] ins;
    oe = 5'b0; o = 5'b0; rd = pp_ctrl_raw; ins = 6'b111101;
    if (own_m == 1) begin
      oe = {1'b0, pp_slin_oe, pp_init_oe, 1'b0, pp_afd_oe};
      o  = oe & {1'b0, pp_slin_o, pp_init_o, 1'b0, pp_afd_o};
      ins = {syn[0], syn[1], syn[2], syn[3], syn[4], 1'b1};
    end else if (own_m >= 2) begin
      oe = {own_m == 3, 4'hf};
      o  = oe & {fd_aux_n_o, fd_step_n_o, fd_dir_n_o, fd_hdsel_n_o, fd_densel_n_o};
      rd = 4'b0100;
      if (own_m == 2) ins[0] = syn[4];
    end
    return {oe, o, rd, ins};
  endfunction

  task automatic check_now(string req, logic [19:0] exp_v);
    logic [19:0] act;
    act = observed();
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.due != cyc) begin
        checks++; fails++;
        $display("FAIL %s: item due %0d missed, actual cycle %0d expected cycle %0d", it.req, it.due, cyc, it.due);
      end else begin
        check_now(it.req, it.v);
      end
    end
  end

  task automatic set_cfg(logic [1:0] m, logic p, string req);
    @(negedge clk);
    cfg_fdd_mode = m; cfg_pp_power = p;
    own_m = owner_of(m, p);
    q.push_back('{cyc + 1, req, expected()});
    repeat (2) @(negedge clk);
  endtask

  task automatic set_pads(logic [4:0] v, string req);
    @(negedge clk);
    pad_i = v;
    q.push_back('{cyc + 1, req, expected()});
    syn = v;
    q.push_back('{cyc + 2, req, expected()});
    repeat (3) @(negedge clk);
  endtask

  task automatic set_pp_drv(logic [5:0] d, logic [3:0] raw, string req);
    @(negedge clk);
    {pp_afd_o, pp_afd_oe, pp_init_o, pp_init_oe, pp_slin_o, pp_slin_oe} = d;
    pp_ctrl_raw = raw;
    q.push_back('{cyc + 1, req, expected()});
    repeat (2) @(negedge clk);
  endtask

  task automatic set_fd_drv(logic [4:0] d, string req);
    @(negedge clk);
    {fd_aux_n_o, fd_step_n_o, fd_dir_n_o, fd_hdsel_n_o, fd_densel_n_o} = d;
    q.push_back('{cyc + 1, req, expected()});
    repeat (2) @(negedge clk);
  endtask

  initial begin
    cfg_fdd_mode = 2'b10; cfg_pp_power = 1'b1;
    pp_ctrl_raw = 4'b1011;
    repeat (3) @(negedge clk);
    own_m = 0;
    check_now("R1", expected());
    @(negedge clk);
    cfg_fdd_mode = 2'b00; cfg_pp_power = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    set_pp_drv(6'b011110, 4'b1011, "R3");
    set_cfg(2'b00, 1'b1, "R2 R9");
    set_pp_drv(6'b110101, 4'b0110, "R2");
    set_pads(5'b01010, "R7");
    set_pads(5'b10101, "R7");
    set_cfg(2'b11, 1'b1, "R2");
    set_pp_drv(6'b111111, 4'b1111, "R2");
    set_cfg(2'b00, 1'b0, "R3 R8");
    set_pads(5'b00000, "R8");
    set_fd_drv(5'b10110, "R3");
    set_cfg(2'b01, 1'b0, "R4 R5 R6 R9");
    set_pads(5'b01111, "R7 R8");
    set_pads(5'b10000, "R5 R7");
    set_fd_drv(5'b01001, "R4");
    set_cfg(2'b10, 1'b0, "R5 R6 R9");
    set_fd_drv(5'b11010, "R5");
    set_pads(5'b01100, "R8");
    set_cfg(2'b10, 1'b1, "R4");
    set_cfg(2'b01, 1'b1, "R4 R5 R6");
    set_pads(5'b00011, "R5 R7");
    set_cfg(2'b00, 1'b1, "R6 R9");
    set_pads(5'b11001, "R7");
    set_cfg(2'b11, 1'b0, "R3");
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule